// File: doc/BRIEF.md
# GPIO Interrupt Latch with Separate Capture and Forward Enables

This block senses interrupt conditions on a bank of general-purpose input pins, records each one in a sticky per-pin status bit and drives one summary interrupt line towards a processor. Every pin has its own settings. A trigger-type bit selects edge or level sensing. A polarity bit selects rising edge or active-high level, or falling edge or active-low level. Two separate enables act on each pin. The capture enable decides whether a detected condition may set the status bit. The forward enable decides whether a set status bit drives the summary line.

With two enables, software has two ways to mask a pin. It can clear only the forward enable. The pin then keeps recording events, and those events reach the processor once forwarding is switched back on. It can also clear the capture enable. The pin then records nothing at all. The second way matters for level interrupts: while the line is still asserted, an acknowledge would otherwise be undone at once.

Each pin's status is a two-state machine. The states are Clear and Pending. A trigger moves the pin from Clear to Pending. A write-one-to-clear acknowledge moves it from Pending back to Clear, but only when no trigger arrives in the same cycle. In all other cases Pending holds. Inputs pass through a two-flop synchronizer first. The summary line is registered.

Top module: `pinirq_latch_top`

## Requirements
- R1: After reset, every readable register reads zero and irq_out is low. Zero means all status bits clear, both enables off, every pin level type (trigger-type bit 0) and active high (polarity bit 0).
- R2: A pin that is level type, active high, with capture enabled, shows its status bit set three clock edges after pin_in rises: two synchronizer flops plus the status flop. After two edges the bit is still clear.
- R3: A status bit stays set after its input deasserts. Writing a 1 to that bit at address 0 clears it at the same edge.
- R4: While a pin's capture enable (address 1) is 0, no condition on that pin sets its status bit. This includes an asserted level that is still present after an acknowledge.
- R5: irq_out is registered. It follows the OR of status AND forward enable (address 2) one edge later, and it is low while every forward enable is 0.
- R6: With trigger type 1 (edge, address 3) and polarity 0, only a rising input sets status. A steady high input does not set status again after an acknowledge.
- R7: Polarity 1 (address 4) selects a falling edge for edge-type pins and a low level for level-type pins.
- R8: An edge that arrives while capture is enabled and forwarding is disabled is held in status. irq_out rises one edge after forwarding is enabled.
- R9: If an acknowledge and a trigger reach the same pin in the same cycle, the status bit stays set.
- R10: On an edge-type pin, clearing and then setting the capture enable while the input stays steady creates no status.
- R11: irq_out stays high while any forwarded pin is pending. It falls only after the last forwarded pending bit is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Raw asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 status ack, 1 capture enable, 2 forward enable, 3 trigger type, 4 polarity |
| wr_data | input | NPIN | Write data, one bit per pin |
| rd_addr | input | 3 | Read address, same map as wr_addr; other addresses read 0 |
| rd_data | output | NPIN | Combinational read data |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
Two events can land on one pin's status bit in the same cycle: a trigger that sets it and an acknowledge that clears it. The bench provokes this by holding a level-type pin asserted with capture enabled and then writing the acknowledge. The bit must stay Pending. The bench then clears capture and repeats the acknowledge, and this time the bit must stay Clear. The same cycle overlap also occurs between a forward-enable write and the summary register, which is judged by sampling irq_out at the edge of the write and at the edge after it.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_PEND  = 1'b1
    } pin_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_CAPT = 3'd1;
    localparam logic [ADDR_W-1:0] A_FWD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TYPE = 3'd3;
    localparam logic [ADDR_W-1:0] A_POL  = 3'd4;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int W     = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pinirq_cell.sv
module pinirq_cell
    import pinirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic capt_en,
    input  logic edge_mode,
    input  logic pol,
    input  logic ack,
    output logic pend
);
    pin_state_e st, st_nx;
    logic prev;
    logic edge_hit, lvl_hit, trig;

    // previous sample tracks the line every cycle, independent of enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= smp;
    end

    always_comb begin
        edge_hit = pol ? (~smp & prev) : (smp & ~prev);
        lvl_hit  = smp ^ pol;
        trig     = capt_en & (edge_mode ? edge_hit : lvl_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_CLEAR;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_CLEAR: if (trig) st_nx = ST_PEND;
            ST_PEND:  if (ack && !trig) st_nx = ST_CLEAR;
            default:  st_nx = ST_CLEAR;
        endcase
    end

    always_comb pend = (st == ST_PEND);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PEND && !ack) |=> st == ST_PEND);
    // R4
    capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capt_en && st == ST_CLEAR) |=> st == ST_CLEAR);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && capt_en && !edge_mode && (smp ^ pol)) |=> st == ST_PEND);
    // R10
    steady_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $stable(smp) && st == ST_CLEAR) |=> st == ST_CLEAR);
endmodule

// File: rtl/pinirq_summary.sv
module pinirq_summary #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] fwd_en,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend & fwd_en);
    end

    // R5
    fwd_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en == '0) |=> !irq);
endmodule

// File: rtl/pinirq_latch_top.sv
module pinirq_latch_top
    import pinirq_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [NPIN-1:0] wr_data,
    input  logic [2:0]      rd_addr,
    output logic [NPIN-1:0] rd_data,
    output logic            irq_out
);
    logic [NPIN-1:0] smp, pend, ack_vec;
    logic [NPIN-1:0] capt_q, fwd_q, type_q, pol_q;

    pinirq_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            capt_q <= '0;
            fwd_q  <= '0;
            type_q <= '0;
            pol_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CAPT) capt_q <= wr_data;
            if (wr_addr == A_FWD)  fwd_q  <= wr_data;
            if (wr_addr == A_TYPE) type_q <= wr_data;
            if (wr_addr == A_POL)  pol_q  <= wr_data;
        end
    end

    always_comb ack_vec = (wr_en && wr_addr == A_STAT) ? wr_data : '0;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        pinirq_cell u_cell (
            .clk(clk), .rst_n(rst_n), .smp(smp[g]),
            .capt_en(capt_q[g]), .edge_mode(type_q[g]), .pol(pol_q[g]),
            .ack(ack_vec[g]), .pend(pend[g])
        );
    end

    pinirq_summary #(.W(NPIN)) u_sum (
        .clk(clk), .rst_n(rst_n), .pend(pend), .fwd_en(fwd_q), .irq(irq_out)
    );

    always_comb begin
        case (rd_addr)
            A_STAT:  rd_data = pend;
            A_CAPT:  rd_data = capt_q;
            A_FWD:   rd_data = fwd_q;
            A_TYPE:  rd_data = type_q;
            A_POL:   rd_data = pol_q;
            default: rd_data = '0;
        endcase
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_out && pend == '0));
endmodule

// File: tb/sim_pinirq_latch_top.sv
module sim_pinirq_latch_top;
    localparam int NPIN = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin_in = '0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_addr = '0;
    logic [NPIN-1:0] wr_data = '0;
    logic [2:0]      rd_addr = '0;
    logic [NPIN-1:0] rd_data;
    logic            irq_out;

    always #2.5 clk = ~clk;

    pinirq_latch_top #(.NPIN(NPIN)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    typedef struct {
        string          req;
        bit             is_irq;
        logic [2:0]     addr;
        logic [NPIN-1:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done = 0;
    event mon_go, mon_done;

    // monitor: pops expected items and compares against ports
    initial begin
        forever begin
            @(mon_go);
            while (q.size() > 0) begin
                item_t it;
                logic [NPIN-1:0] act;
                it = q.pop_front();
                rd_addr = it.addr;
                #0.5;
                act = it.is_irq ? {{(NPIN-1){1'b0}}, irq_out} : rd_data;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%0d irq=%0d actual=%h expected=%h",
                             it.req, it.addr, it.is_irq, act, it.exp);
                end
            end
            ->mon_done;
        end
    end

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [NPIN-1:0] e);
        item_t it;
        it.req = req; it.is_irq = 0; it.addr = a; it.exp = e;
        q.push_back(it);
        ->mon_go;
        @(mon_done);
    endtask

    task automatic expect_irq(input string req, input logic e);
        item_t it;
        it.req = req; it.is_irq = 1; it.addr = 3'd0; it.exp = {{(NPIN-1){1'b0}}, e};
        q.push_back(it);
        ->mon_go;
        @(mon_done);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NPIN-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        for (int a = 0; a < 5; a++) expect_reg("R1", a[2:0], '0);
        expect_irq("R1", 1'b0);

        // R4 capture disabled: asserted level ignored
        pin_in[0] = 1'b1;
        step(4);
        expect_reg("R4", 3'd0, 8'h00);
        pin_in[0] = 1'b0;
        step(3);

        // R2 latency through synchronizer
        wr(3'd1, 8'h01);
        pin_in[0] = 1'b1;
        step(2);
        expect_reg("R2", 3'd0, 8'h00);
        step(1);
        expect_reg("R2", 3'd0, 8'h01);
        expect_irq("R5", 1'b0);

        // R5 forward enable, registered summary
        wr(3'd2, 8'h01);
        expect_irq("R5", 1'b0);
        step(1);
        expect_irq("R5", 1'b1);

        // R3 sticky then W1C
        pin_in[0] = 1'b0;
        step(4);
        expect_reg("R3", 3'd0, 8'h01);
        wr(3'd0, 8'h01);
        expect_reg("R3", 3'd0, 8'h00);
        step(1);
        expect_irq("R3", 1'b0);

        // R9 ack during asserted level: set wins
        pin_in[0] = 1'b1;
        step(3);
        expect_reg("R9", 3'd0, 8'h01);
        wr(3'd0, 8'h01);
        expect_reg("R9", 3'd0, 8'h01);
        // R4 capture off then ack: stays clear
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h01);
        expect_reg("R4", 3'd0, 8'h00);
        step(3);
        expect_reg("R4", 3'd0, 8'h00);
        pin_in[0] = 1'b0;
        step(3);
        wr(3'd1, 8'h01);
        step(2);
        expect_reg("R4", 3'd0, 8'h00);

        // R6 / R8 edge on pin 1 with forwarding off
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h02);
        wr(3'd1, 8'h03);
        pin_in[1] = 1'b1;
        step(3);
        expect_reg("R6", 3'd0, 8'h02);
        step(1);
        expect_irq("R8", 1'b0);
        wr(3'd2, 8'h02);
        step(1);
        expect_irq("R8", 1'b1);
        wr(3'd0, 8'h02);
        step(3);
        expect_reg("R6", 3'd0, 8'h00);

        // R10 toggle capture with steady high line
        wr(3'd1, 8'h01);
        step(2);
        wr(3'd1, 8'h03);
        step(3);
        expect_reg("R10", 3'd0, 8'h00);

        // R7 falling edge on pin 1, active-low level on pin 2
        wr(3'd4, 8'h02);
        pin_in[1] = 1'b0;
        step(3);
        expect_reg("R7", 3'd0, 8'h02);
        wr(3'd4, 8'h06);
        wr(3'd1, 8'h07);
        step(1);
        expect_reg("R7", 3'd0, 8'h06);

        // R11 summary OR across pins
        wr(3'd2, 8'h06);
        step(1);
        expect_irq("R11", 1'b1);
        wr(3'd0, 8'h02);
        step(2);
        expect_reg("R11", 3'd0, 8'h04);
        expect_irq("R11", 1'b1);
        pin_in[2] = 1'b1;
        step(3);
        wr(3'd0, 8'h04);
        step(2);
        expect_reg("R11", 3'd0, 8'h00);
        expect_irq("R11", 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule